// File: doc/BRIEF.md
# DRAM Open-Row Tracking Table

This block sits in the front end of a DRAM memory controller. It keeps a small table of the rows that are currently open. Each entry is keyed by bank and sub-bank. For each new transaction it decides which command sequence the controller must issue. A column access is enough when the row is already open. A bare activate is enough when the bank is idle and a slot is free. A precharge followed by an activate is needed when a row must be closed first. The table also closes rows on its own when they sit unused for too long, and when a refresh is requested.

Alongside the decision, the block produces one-cycle strobes and small per-cycle counts for a performance monitor. Hits and misses are split two ways. One split is whether another transaction was already outstanding when this one issued. The other is whether the transaction is a read. Row collisions get a strobe of their own. Precharges caused by anything other than refresh are counted separately from all forced closings. All outputs are registered and appear one cycle after the request that caused them.

Top module: `orow_table`

## Requirements
- R1: A request whose bank and sub-bank match an open entry holding the same row yields cmd_kind 1 (column access) on the cycle after the request, with no precharge counted.
- R2: A request whose bank and sub-bank match an open entry holding a different row yields cmd_kind 3 (precharge then activate) and pulses evt_collide. It reports pre_num 1 and close_num 1, and afterwards the new row is the open one for that bank and sub-bank.
- R3: A request with no bank and sub-bank match, while a slot is free, yields cmd_kind 2 (activate) with pre_num 0 and no collision strobe. It takes the lowest-numbered free slot.
- R4: A request with no match while all slots hold open rows evicts the entry whose last request lies furthest back. It yields cmd_kind 3 with pre_num 1; every other entry stays open.
- R5: Any request that lands on an entry reloads its idle counter with idle_limit. An entry that then sees no request is closed on the idle_limit-th clock edge after that request, counted once in pre_num and close_num. An entry loaded while idle_limit is 0 is never closed by idling.
- R6: A refresh closes every open row in that cycle. close_num counts those rows, but pre_num does not. A request in the same cycle is classified against an empty table.
- R7: For each request exactly one of the read-or-write strobes pulses: hit-pipelined, hit-solo, miss-pipelined or miss-solo. "Pipelined" means req_busy was 1 with the request. The read-only strobe of the same class also pulses when req_write is 0.
- R8: Outputs are registered. In a cycle after a cycle with no request, cmd_kind is 0 and every hit, miss and collision strobe is 0.
- R9: After reset the table is empty and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A new transaction issues this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_bank | input | BANK_W | Bank of the transaction |
| req_sub | input | SUB_W | Sub-bank of the transaction |
| req_row | input | ROW_W | Row of the transaction |
| req_busy | input | 1 | Another transaction is already outstanding |
| refresh | input | 1 | Close all rows this cycle |
| idle_limit | input | IDLE_W | Idle-close interval in cycles; 0 disables |
| cmd_kind | output | 2 | 0 none, 1 column access, 2 activate, 3 precharge then activate |
| evt_rd_hit_pipe | output | 1 | Read hit with another transaction outstanding |
| evt_rd_hit_solo | output | 1 | Read hit with nothing outstanding |
| evt_rw_hit_pipe | output | 1 | Read or write hit, outstanding |
| evt_rw_hit_solo | output | 1 | Read or write hit, nothing outstanding |
| evt_rd_miss_pipe | output | 1 | Read miss, outstanding |
| evt_rd_miss_solo | output | 1 | Read miss, nothing outstanding |
| evt_rw_miss_pipe | output | 1 | Read or write miss, outstanding |
| evt_rw_miss_solo | output | 1 | Read or write miss, nothing outstanding |
| evt_collide | output | 1 | Row collision forced a close |
| pre_num | output | CW | Precharges this cycle, refresh excluded |
| close_num | output | CW | All forced closings this cycle, refresh included |

## Verification
A corrupted row, bank or valid bit turns a later hit into a miss, or the reverse. That shows in cmd_kind and in the hit/miss strobes one cycle after the next request to that bank. A wrong replacement rank shows up as a later hit that unexpectedly reports an activate, once a full table evicts the wrong entry. A wrong idle count moves the pre_num pulse off its expected edge, so it is seen within idle_limit cycles of the last access.

// File: rtl/orow_pkg.sv
package orow_pkg;
  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_COL     = 2'd1,
    CMD_ACT     = 2'd2,
    CMD_PRE_ACT = 2'd3
  } cmd_e;
endpackage

// File: rtl/orow_match.sv
module orow_match #(
  parameter int ENTRIES = 4,
  parameter int BANK_W  = 3,
  parameter int SUB_W   = 1,
  parameter int ROW_W   = 14
) (
  input  logic [ENTRIES-1:0]             ent_valid,
  input  logic [ENTRIES-1:0][BANK_W-1:0] ent_bank,
  input  logic [ENTRIES-1:0][SUB_W-1:0]  ent_sub,
  input  logic [ENTRIES-1:0][ROW_W-1:0]  ent_row,
  input  logic [BANK_W-1:0]              key_bank,
  input  logic [SUB_W-1:0]               key_sub,
  input  logic [ROW_W-1:0]               key_row,
  output logic [ENTRIES-1:0]             bank_hit,
  output logic [ENTRIES-1:0]             row_hit
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign bank_hit[g] = ent_valid[g] && (ent_bank[g] == key_bank) && (ent_sub[g] == key_sub);
    assign row_hit[g]  = bank_hit[g] && (ent_row[g] == key_row);
  end
endmodule

// File: rtl/orow_lru.sv
module orow_lru #(
  parameter int ENTRIES = 4,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  logic [ENTRIES-1:0][IW-1:0] rank_q, rank_d;

  always_comb begin
    rank_d = rank_q;
    if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IW'(i) == touch_idx)                rank_d[i] = '0;
        else if (rank_q[i] < rank_q[touch_idx]) rank_d[i] = rank_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (rank_q[i] == IW'(ENTRIES-1)) victim_idx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IW'(i);
    end else if (touch_en) begin
      rank_q <= rank_d;
    end
  end
endmodule

// File: rtl/orow_table.sv
module orow_table import orow_pkg::*; #(
  parameter int ENTRIES = 4,
  parameter int BANK_W  = 3,
  parameter int SUB_W   = 1,
  parameter int ROW_W   = 14,
  parameter int IDLE_W  = 8,
  localparam int CW = $clog2(ENTRIES+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [SUB_W-1:0]  req_sub,
  input  logic [ROW_W-1:0]  req_row,
  input  logic              req_busy,
  input  logic              refresh,
  input  logic [IDLE_W-1:0] idle_limit,
  output logic [1:0]        cmd_kind,
  output logic              evt_rd_hit_pipe,
  output logic              evt_rd_hit_solo,
  output logic              evt_rw_hit_pipe,
  output logic              evt_rw_hit_solo,
  output logic              evt_rd_miss_pipe,
  output logic              evt_rd_miss_solo,
  output logic              evt_rw_miss_pipe,
  output logic              evt_rw_miss_solo,
  output logic              evt_collide,
  output logic [CW-1:0]     pre_num,
  output logic [CW-1:0]     close_num
);
  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             valid_q, valid_d, eff_valid, load, expire, free_vec;
  logic [ENTRIES-1:0][BANK_W-1:0] bank_q;
  logic [ENTRIES-1:0][SUB_W-1:0]  sub_q;
  logic [ENTRIES-1:0][ROW_W-1:0]  row_q;
  logic [ENTRIES-1:0][IDLE_W-1:0] cnt_q, cnt_d;
  logic [ENTRIES-1:0]             bank_hit, row_hit;
  logic [IW-1:0]                  match_idx, free_idx, victim_idx, slot;
  logic                           any_match, any_hit, any_free, collide, evict;
  cmd_e                           kind_d;
  logic [7:0]                     evt_d, evt_q;
  logic [CW-1:0]                  pre_d, close_d, ref_cnt;

  // A refresh wipes the table before the request in the same cycle is seen.
  assign eff_valid = refresh ? '0 : valid_q;

  orow_match #(.ENTRIES(ENTRIES), .BANK_W(BANK_W), .SUB_W(SUB_W), .ROW_W(ROW_W)) u_match (
    .ent_valid(eff_valid), .ent_bank(bank_q), .ent_sub(sub_q), .ent_row(row_q),
    .key_bank(req_bank), .key_sub(req_sub), .key_row(req_row),
    .bank_hit(bank_hit), .row_hit(row_hit)
  );

  orow_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(req_valid), .touch_idx(slot), .victim_idx(victim_idx)
  );

  assign any_match = req_valid && (|bank_hit);
  assign any_hit   = req_valid && (|row_hit);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_expire
    assign expire[g]   = eff_valid[g] && (cnt_q[g] == IDLE_W'(1)) && !(req_valid && bank_hit[g]);
    assign free_vec[g] = !eff_valid[g] || expire[g];
  end

  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    any_free  = 1'b0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (bank_hit[i]) match_idx = IW'(i);
      if (free_vec[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    end
  end

  // Request classification and slot choice
  always_comb begin
    collide = any_match && !any_hit;
    evict   = req_valid && !any_match && !any_free;
    slot    = any_match ? match_idx : (any_free ? free_idx : victim_idx);
    if (!req_valid)     kind_d = CMD_NONE;
    else if (any_hit)   kind_d = CMD_COL;
    else if (any_match) kind_d = CMD_PRE_ACT;
    else if (any_free)  kind_d = CMD_ACT;
    else                kind_d = CMD_PRE_ACT;
    evt_d = {any_hit && !req_write && req_busy,   any_hit && !req_write && !req_busy,
             any_hit && req_busy,                 any_hit && !req_busy,
             req_valid && !any_hit && !req_write && req_busy,
             req_valid && !any_hit && !req_write && !req_busy,
             req_valid && !any_hit && req_busy,   req_valid && !any_hit && !req_busy};
    ref_cnt = refresh ? CW'($countones(valid_q)) : '0;
    pre_d   = CW'($countones(expire)) + CW'(collide) + CW'(evict);
    close_d = pre_d + ref_cnt;
  end

  // Entry next state
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      load[i]    = req_valid && (slot == IW'(i));
      valid_d[i] = (eff_valid[i] && !expire[i]) || load[i];
      if (load[i])                               cnt_d[i] = idle_limit;
      else if (valid_d[i] && cnt_q[i] != '0)     cnt_d[i] = cnt_q[i] - 1'b1;
      else                                       cnt_d[i] = '0;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        cnt_q[g]   <= '0;
        bank_q[g]  <= '0;
        sub_q[g]   <= '0;
        row_q[g]   <= '0;
      end else begin
        valid_q[g] <= valid_d[g];
        cnt_q[g]   <= cnt_d[g];
        if (load[g]) begin
          bank_q[g] <= req_bank;
          sub_q[g]  <= req_sub;
          row_q[g]  <= req_row;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_kind    <= CMD_NONE;
      evt_q       <= '0;
      evt_collide <= 1'b0;
      pre_num     <= '0;
      close_num   <= '0;
    end else begin
      cmd_kind    <= kind_d;
      evt_q       <= evt_d;
      evt_collide <= collide;
      pre_num     <= pre_d;
      close_num   <= close_d;
    end
  end

  assign {evt_rd_hit_pipe, evt_rd_hit_solo, evt_rw_hit_pipe, evt_rw_hit_solo,
          evt_rd_miss_pipe, evt_rd_miss_solo, evt_rw_miss_pipe, evt_rw_miss_solo} = evt_q;
endmodule

// File: rtl/orow_table_chk.sv
module orow_table_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_busy,
  input logic          refresh,
  input logic [1:0]    cmd_kind,
  input logic          evt_rd_hit_pipe,
  input logic          evt_rd_hit_solo,
  input logic          evt_rw_hit_pipe,
  input logic          evt_rw_hit_solo,
  input logic          evt_rd_miss_pipe,
  input logic          evt_rd_miss_solo,
  input logic          evt_rw_miss_pipe,
  input logic          evt_rw_miss_solo,
  input logic          evt_collide,
  input logic [CW-1:0] pre_num,
  input logic [CW-1:0] close_num
);
  p_col_means_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_kind == 2'd1) == (evt_rw_hit_pipe || evt_rw_hit_solo));

  p_collide_precharges_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_collide |-> (cmd_kind == 2'd3) && (pre_num != '0));

  p_act_no_collide_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_kind == 2'd2) |-> !evt_collide);

  p_close_covers_pre_r6: assert property (@(posedge clk) disable iff (!rst_n)
    close_num >= pre_num);

  p_refresh_no_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (cmd_kind != 2'd1));

  p_one_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_rw_hit_pipe, evt_rw_hit_solo, evt_rw_miss_pipe, evt_rw_miss_solo}));

  p_read_in_rw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd_hit_pipe || evt_rd_hit_solo || evt_rd_miss_pipe || evt_rd_miss_solo) |->
    ((evt_rd_hit_pipe == evt_rw_hit_pipe) || !evt_rd_hit_pipe) &&
    ((evt_rd_miss_solo == evt_rw_miss_solo) || !evt_rd_miss_solo));

  p_busy_is_pipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_busy) |=> !evt_rw_hit_solo && !evt_rw_miss_solo);

  p_req_gives_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (cmd_kind != 2'd0));

  p_quiet_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (cmd_kind == 2'd0) && !evt_collide &&
    !(evt_rw_hit_pipe || evt_rw_hit_solo || evt_rw_miss_pipe || evt_rw_miss_solo));
endmodule

bind orow_table orow_table_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_busy(req_busy), .refresh(refresh),
  .cmd_kind(cmd_kind),
  .evt_rd_hit_pipe(evt_rd_hit_pipe), .evt_rd_hit_solo(evt_rd_hit_solo),
  .evt_rw_hit_pipe(evt_rw_hit_pipe), .evt_rw_hit_solo(evt_rw_hit_solo),
  .evt_rd_miss_pipe(evt_rd_miss_pipe), .evt_rd_miss_solo(evt_rd_miss_solo),
  .evt_rw_miss_pipe(evt_rw_miss_pipe), .evt_rw_miss_solo(evt_rw_miss_solo),
  .evt_collide(evt_collide), .pre_num(pre_num), .close_num(close_num)
);

// File: tb/orow_table_test.sv
module orow_table_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int BANK_W = 3, SUB_W = 1, ROW_W = 14, IDLE_W = 8;
  localparam int CW = $clog2(N+1);

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_busy, refresh;
  logic [BANK_W-1:0] req_bank;
  logic [SUB_W-1:0]  req_sub;
  logic [ROW_W-1:0]  req_row;
  logic [IDLE_W-1:0] idle_limit;
  logic [1:0] cmd_kind;
  logic rdhp, rdhs, rwhp, rwhs, rdmp, rdms, rwmp, rwms, collide;
  logic [CW-1:0] pre_num, close_num;

  always #(CLK_PERIOD/2) clk = ~clk;

  orow_table #(.ENTRIES(N), .BANK_W(BANK_W), .SUB_W(SUB_W), .ROW_W(ROW_W), .IDLE_W(IDLE_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_sub(req_sub), .req_row(req_row), .req_busy(req_busy),
    .refresh(refresh), .idle_limit(idle_limit), .cmd_kind(cmd_kind),
    .evt_rd_hit_pipe(rdhp), .evt_rd_hit_solo(rdhs), .evt_rw_hit_pipe(rwhp), .evt_rw_hit_solo(rwhs),
    .evt_rd_miss_pipe(rdmp), .evt_rd_miss_solo(rdms), .evt_rw_miss_pipe(rwmp), .evt_rw_miss_solo(rwms),
    .evt_collide(collide), .pre_num(pre_num), .close_num(close_num)
  );

  typedef struct {
    string      tag;
    logic [1:0] kind;
    logic [7:0] ev;
    logic       col;
    int         pre;
    int         cls;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Reference table
  bit m_valid[N];
  int m_bank[N], m_sub[N], m_row[N], m_cnt[N], m_last[N];
  int tick = 0;

  task automatic cyc(input bit rv, input int bk, input int sb, input int row,
                     input bit wr, input bit bz, input bit rf, input string tag);
    bit ev[N];
    bit ex[N];
    int mi, fi, slot, refn, idn, oldest;
    bit hit, evict;
    exp_t e;
    mi = -1; fi = -1; slot = 0; refn = 0; idn = 0; hit = 0; evict = 0;
    req_valid = rv; req_bank = BANK_W'(bk); req_sub = SUB_W'(sb); req_row = ROW_W'(row);
    req_write = wr; req_busy = bz; refresh = rf;
    for (int i = 0; i < N; i++) begin
      ev[i] = !rf && m_valid[i];
      if (rf && m_valid[i]) refn++;
    end
    for (int i = 0; i < N; i++)
      if (rv && ev[i] && m_bank[i] == bk && m_sub[i] == sb) mi = i;
    hit = (mi >= 0) && (m_row[mi] == row);
    for (int i = 0; i < N; i++) begin
      ex[i] = ev[i] && m_cnt[i] == 1 && !(rv && mi == i);
      if (ex[i]) idn++;
    end
    for (int i = N-1; i >= 0; i--)
      if (!ev[i] || ex[i]) fi = i;
    e.tag = tag; e.kind = 2'd0; e.ev = '0; e.col = 1'b0;
    if (rv) begin
      if (mi >= 0) begin
        slot = mi; e.kind = hit ? 2'd1 : 2'd3; e.col = !hit;
      end else if (fi >= 0) begin
        slot = fi; e.kind = 2'd2;
      end else begin
        oldest = 0;
        for (int i = 1; i < N; i++) if (m_last[i] < m_last[oldest]) oldest = i;
        slot = oldest; e.kind = 2'd3; evict = 1'b1;
      end
      e.ev = {hit && !wr && bz, hit && !wr && !bz, hit && bz, hit && !bz,
              !hit && !wr && bz, !hit && !wr && !bz, !hit && bz, !hit && !bz};
    end
    e.pre = idn + int'(e.col) + int'(evict);
    e.cls = e.pre + refn;
    for (int i = 0; i < N; i++) begin
      m_valid[i] = ev[i] && !ex[i];
      m_cnt[i]   = (m_valid[i] && m_cnt[i] > 0) ? m_cnt[i] - 1 : 0;
    end
    if (rv) begin
      m_valid[slot] = 1'b1; m_bank[slot] = bk; m_sub[slot] = sb; m_row[slot] = row;
      m_cnt[slot] = int'(idle_limit); m_last[slot] = tick;
    end
    tick++;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: compare outputs one step after each active edge
  always @(posedge clk) begin
    exp_t e;
    logic [7:0] act;
    #1;
    if (q.size() > 0 && !done) begin
      e = q.pop_front();
      act = {rdhp, rdhs, rwhp, rwhs, rdmp, rdms, rwmp, rwms};
      checks++;
      if (cmd_kind !== e.kind || act !== e.ev || collide !== e.col ||
          int'(pre_num) != e.pre || int'(close_num) != e.cls) begin
        errors++;
        $display("FAIL %s: kind=%0d ev=%b col=%0d pre=%0d close=%0d expected kind=%0d ev=%b col=%0d pre=%0d close=%0d",
                 e.tag, cmd_kind, act, collide, pre_num, close_num,
                 e.kind, e.ev, e.col, e.pre, e.cls);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_busy = 0; refresh = 0;
    req_bank = '0; req_sub = '0; req_row = '0; idle_limit = '0;
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_cnt[i] = 0; m_last[i] = -1;
      m_bank[i] = 0; m_sub[i] = 0; m_row[i] = 0;
    end
    repeat (3) @(negedge clk);
    checks++;  // R9 reset state
    if (cmd_kind !== 2'd0 || {rdhp, rdhs, rwhp, rwhs, rdmp, rdms, rwmp, rwms, collide} !== '0 ||
        pre_num !== '0 || close_num !== '0) begin
      errors++;
      $display("FAIL R9: kind=%0d pre=%0d close=%0d expected all zero", cmd_kind, pre_num, close_num);
    end
    rst_n = 1'b1;
    @(negedge clk);

    cyc(1, 0, 0, 5, 0, 0, 0, "R3 first read miss activates");
    cyc(1, 0, 0, 5, 0, 1, 0, "R1 read hit pipelined");
    cyc(1, 0, 0, 5, 1, 0, 0, "R7 write hit solo");
    cyc(1, 0, 0, 9, 1, 1, 0, "R2 row collision");
    idle(1, "R8 no request");
    cyc(1, 1, 0, 3, 0, 0, 0, "R3 fill bank1");
    cyc(1, 2, 1, 4, 0, 1, 0, "R3 fill bank2 sub1");
    cyc(1, 3, 0, 6, 1, 0, 0, "R3 fill bank3");
    cyc(1, 0, 0, 9, 0, 0, 0, "R2 new row stays open");
    cyc(1, 4, 0, 7, 0, 1, 0, "R4 evict oldest bank1");
    cyc(1, 1, 0, 3, 0, 0, 0, "R4 evicted bank misses");
    cyc(1, 0, 0, 9, 0, 1, 0, "R4 survivor still hits");
    cyc(1, 2, 1, 4, 0, 0, 0, "R4 wrong entry kept check");
    cyc(0, 0, 0, 0, 0, 0, 1, "R6 refresh closes all");
    cyc(1, 0, 0, 9, 0, 0, 0, "R6 table empty after refresh");
    cyc(1, 0, 0, 9, 0, 1, 1, "R6 request with refresh");
    idle_limit = 8'd3;
    cyc(1, 5, 1, 11, 0, 0, 0, "R5 open with limit 3");
    idle(3, "R5 idle expiry");
    cyc(1, 5, 1, 11, 1, 1, 0, "R5 reopen after expiry");
    idle(1, "R5 wait");
    cyc(1, 5, 1, 11, 0, 0, 0, "R5 access reloads");
    idle(3, "R5 expiry after reload");
    idle_limit = 8'd0;
    idle(5, "R5 zero limit keeps row");
    cyc(1, 0, 0, 9, 0, 0, 0, "R5 zero limit row still open");
    idle(2, "R8 flush");
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule